// File: doc/BRIEF.md
# Retriggerable strobe one-shot counter

This block is a 16-bit down-counter that produces a single active-low strobe, one clock wide, when a programmed count runs out. A configuration write picks one of two trigger sources. In software-trigger mode, completing a count write starts the sequence, and any later completed write restarts it. In gate-trigger mode, a rising edge on the gate input starts or restarts the sequence from the most recently written count.

The count arrives one byte at a time. It is taken either as a single low byte or as a low/high byte pair. The counter can run as a plain binary counter or as a four-digit decimal (BCD) counter. The clock that loads the count does not decrement it. After the strobe the counter keeps running and wraps around without strobing again until the next trigger. A configuration write returns the output to its idle level at once and drops any sequence in progress.

Top module: `oneshot_strobe_timer`

## Requirements
- R1: After reset `out_n` is 1, and every strobe holds `out_n` at 0 for exactly one clock.
- R2: Let k be the clock edge that samples the completing count write (software mode) or the trigger (gate mode). The count N is loaded at edge k+1 without being decremented, and `out_n` is 0 during the cycle that follows edge k+N+1.
- R3: In software mode, completing a count write is the trigger, and gate edges start nothing.
- R4: In software mode, a count completed while a sequence runs is loaded on the next clock, and the strobe of the replaced sequence never appears.
- R5: With `cw_two_byte`=1, the first byte written gives count bits 7:0 and has no effect on a running sequence. The second byte gives bits 15:8 and completes the write. With `cw_two_byte`=0, each byte is the whole count and bits 15:8 are 0.
- R6: In software mode, an edge that samples `gate`=0 does not decrement the count, and `gate` never changes `out_n` directly.
- R7: In gate mode, a trigger is an edge that samples `gate`=1 after an edge that sampled 0. A count write alone starts nothing, and triggers that arrive before any count has been completed since the last configuration write are ignored.
- R8: In gate mode, every trigger restarts the sequence from the latest completed count. A count written while a sequence runs leaves that sequence's timing unchanged.
- R9: After the strobe the counter keeps decrementing and wraps from 0 to all nines (BCD) or all ones (binary), with no further strobe until the next trigger.
- R10: With `cw_bcd`=1 the count is four decimal digits. A written count of 0 stands for 10000 in BCD mode and for 65536 in binary mode.
- R11: While `cw_wr` is 1, `out_n` is 1 in the same cycle. The edge that samples `cw_wr` latches `cw_gate_trig`, `cw_bcd` and `cw_two_byte`, cancels any running or pending sequence and discards a half-written count. A count write sampled on that same edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cw_wr | input | 1 | Configuration write strobe |
| cw_gate_trig | input | 1 | Trigger source: 0 = software write, 1 = gate rising edge |
| cw_bcd | input | 1 | Count format: 0 = binary, 1 = BCD |
| cw_two_byte | input | 1 | Count width: 0 = low byte only, 1 = low then high byte |
| cnt_wr | input | 1 | Count byte write strobe |
| cnt_byte | input | 8 | Count byte |
| gate | input | 1 | Gate: pauses counting in software mode, triggers in gate mode |
| out_n | output | 1 | Active-low one-clock strobe |

## Verification
The bench builds the block with its default 16-bit count and 8-bit byte width. At these values a written count of 0 runs the full 65536-clock binary span and the 10000-clock BCD span within one run, so the wrap boundaries of both formats are reached. The byte width is half the count width, which brings the two-byte sequencing within reach, including a low byte written into a running sequence.

// File: rtl/oneshot_pkg.sv
// Shared types for the one-shot strobe counter.
package oneshot_pkg;

    // Source that starts a counting sequence
    typedef enum logic {
        TRIG_SOFT = 1'b0,
        TRIG_GATE = 1'b1
    } trig_src_e;

    // Latched configuration word
    typedef struct packed {
        trig_src_e src;
        logic      bcd;
        logic      two_byte;
    } ctl_word_t;

endpackage

// File: rtl/oneshot_byte_asm.sv
// Assembles the count from byte writes.
// In one-byte mode each write completes a count with the high part zero.
// In two-byte mode the first write holds the low byte and the second
// write completes the count. A completed count raises cnt_done for one
// cycle and sets cnt_valid until the next clear.
// Assumes CNT_W == 2*BYTE_W.
module oneshot_byte_asm #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              two_byte,
    input  logic              wr,
    input  logic [BYTE_W-1:0] data,
    output logic [CNT_W-1:0]  cnt_full,
    output logic              cnt_done,
    output logic              cnt_valid
);
    localparam int HI_W = CNT_W - BYTE_W;

    logic              hi_next_q;
    logic [BYTE_W-1:0] lo_q;

    // Byte pointer, low-byte holding register and completed count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_next_q <= 1'b0;
            lo_q      <= '0;
            cnt_full  <= '0;
            cnt_done  <= 1'b0;
            cnt_valid <= 1'b0;
        end else begin
            cnt_done <= 1'b0;
            if (clear) begin
                hi_next_q <= 1'b0;
                cnt_valid <= 1'b0;
            end else if (wr) begin
                if (two_byte && !hi_next_q) begin
                    lo_q      <= data;
                    hi_next_q <= 1'b1;
                end else if (two_byte) begin
                    cnt_full  <= {data[HI_W-1:0], lo_q};
                    hi_next_q <= 1'b0;
                    cnt_done  <= 1'b1;
                    cnt_valid <= 1'b1;
                end else begin
                    cnt_full  <= {{HI_W{1'b0}}, data};
                    cnt_done  <= 1'b1;
                    cnt_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/oneshot_gate_trig.sv
// Detects a rising edge of the gate input, sampled on the clock, and
// registers it as a one-cycle load request while gate-trigger mode is
// selected. Assumes gate is already synchronous to clk.
module oneshot_gate_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic gate_mode,
    input  logic gate,
    output logic trig_pend
);
    logic gate_q;

    // Previous gate sample and edge-triggered load request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q    <= 1'b0;
            trig_pend <= 1'b0;
        end else begin
            gate_q    <= gate;
            trig_pend <= gate_mode && gate && !gate_q && !clear;
        end
    end
endmodule

// File: rtl/oneshot_dec_unit.sv
// Next value of a down-counter, binary or BCD, selected at run time.
// The BCD path borrows digit by digit, so 0 wraps to all nines.
// The binary path wraps 0 to all ones. Assumes CNT_W is a multiple of 4.
module oneshot_dec_unit #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] value,
    input  logic             bcd,
    output logic [CNT_W-1:0] next
);
    localparam int DIGITS = CNT_W / 4;

    logic [DIGITS:0]    brw;
    logic [CNT_W-1:0]   bcd_next;

    assign brw[0] = 1'b1;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [3:0] dig;
        assign dig = value[4*g +: 4];
        assign bcd_next[4*g +: 4] = brw[g] ? ((dig == 4'd0) ? 4'd9 : dig - 4'd1) : dig;
        assign brw[g+1] = brw[g] && (dig == 4'd0);
    end

    // Pick the decrement style for the current format
    always_comb begin
        next = bcd ? bcd_next : value - CNT_W'(1);
    end
endmodule

// File: rtl/oneshot_strobe_timer.sv
// Retriggerable one-shot strobe counter (top).
// A completed count write (software mode) or a gate rising edge (gate
// mode) loads the count one clock later, without decrementing on that
// clock. When the count steps from 1 to 0 while armed, out_n drops for
// one clock. The counter then keeps wrapping silently until retriggered.
// A configuration write forces out_n high in the same cycle and clears
// the sequence. Assumes all inputs are synchronous to clk.
module oneshot_strobe_timer
    import oneshot_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_wr,
    input  logic              cw_gate_trig,
    input  logic              cw_bcd,
    input  logic              cw_two_byte,
    input  logic              cnt_wr,
    input  logic [BYTE_W-1:0] cnt_byte,
    input  logic              gate,
    output logic              out_n
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    ctl_word_t         ctl_q;
    logic              hw_mode;
    logic [CNT_W-1:0]  cnt_full;
    logic              cnt_done;
    logic              cnt_valid;
    logic              trig_pend;
    logic              load_now;
    logic              cnt_en;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_dec;
    logic              armed_q;
    logic              running_q;
    logic              strobe_q;

    // Configuration word latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{src: TRIG_SOFT, bcd: 1'b0, two_byte: 1'b0};
        end else if (cw_wr) begin
            ctl_q <= '{src: trig_src_e'(cw_gate_trig), bcd: cw_bcd, two_byte: cw_two_byte};
        end
    end

    assign hw_mode = (ctl_q.src == TRIG_GATE);

    oneshot_byte_asm #(
        .CNT_W  (CNT_W),
        .BYTE_W (BYTE_W)
    ) asm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cw_wr),
        .two_byte  (ctl_q.two_byte),
        .wr        (cnt_wr),
        .data      (cnt_byte),
        .cnt_full  (cnt_full),
        .cnt_done  (cnt_done),
        .cnt_valid (cnt_valid)
    );

    oneshot_gate_trig trig_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cw_wr),
        .gate_mode (hw_mode),
        .gate      (gate),
        .trig_pend (trig_pend)
    );

    oneshot_dec_unit #(
        .CNT_W (CNT_W)
    ) dec_i (
        .value (cnt_q),
        .bcd   (ctl_q.bcd),
        .next  (cnt_dec)
    );

    // Load request and count enable for the selected trigger source
    always_comb begin
        load_now = hw_mode ? (trig_pend && cnt_valid) : cnt_done;
        cnt_en   = hw_mode || gate;
    end

    // Count register, armed flag and one-clock strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            armed_q   <= 1'b0;
            running_q <= 1'b0;
            strobe_q  <= 1'b0;
        end else if (cw_wr) begin
            cnt_q     <= '0;
            armed_q   <= 1'b0;
            running_q <= 1'b0;
            strobe_q  <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            if (load_now) begin
                cnt_q     <= cnt_full;
                armed_q   <= 1'b1;
                running_q <= 1'b1;
            end else if (running_q && cnt_en) begin
                cnt_q <= cnt_dec;
                if (armed_q && cnt_q == CNT_ONE) begin
                    strobe_q <= 1'b1;
                    armed_q  <= 1'b0;
                end
            end
        end
    end

    // Output: strobe low, released at once by a configuration write
    assign out_n = !strobe_q || cw_wr;
endmodule

// File: rtl/oneshot_strobe_chk.sv
// Assertion checker for oneshot_strobe_timer, attached by bind.
module oneshot_strobe_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cw_wr,
    input logic             out_n,
    input logic             load_now,
    input logic             cnt_en,
    input logic             bcd,
    input logic [CNT_W-1:0] cnt_full,
    input logic [CNT_W-1:0] cnt_q,
    input logic             armed_q,
    input logic             running_q
);
    localparam int DIGITS = CNT_W / 4;

    // R1
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_n |=> out_n);

    // R11
    cw_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cw_wr |-> out_n);

    // R11
    cw_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cw_wr |=> (!armed_q && !running_q && out_n));

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_now && !cw_wr) |=> (cnt_q == $past(cnt_full) && armed_q));

    // R6
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && !cnt_en && !load_now && !cw_wr) |=> $stable(cnt_q));

    // R9
    no_restrobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |=> out_n);

    // R9
    bin_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && cnt_en && !load_now && !cw_wr && !bcd && cnt_q == '0)
        |=> (cnt_q == {CNT_W{1'b1}}));

    // R10
    bcd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && cnt_en && !load_now && !cw_wr && bcd && cnt_q == '0)
        |=> (cnt_q == {DIGITS{4'h9}}));
endmodule

bind oneshot_strobe_timer oneshot_strobe_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cw_wr     (cw_wr),
    .out_n     (out_n),
    .load_now  (load_now),
    .cnt_en    (cnt_en),
    .bcd       (ctl_q.bcd),
    .cnt_full  (cnt_full),
    .cnt_q     (cnt_q),
    .armed_q   (armed_q),
    .running_q (running_q)
);

// File: tb/oneshot_strobe_timer_tb_top.sv
module oneshot_strobe_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cw_wr = 1'b0;
    logic       cw_gate_trig = 1'b0;
    logic       cw_bcd = 1'b0;
    logic       cw_two_byte = 1'b0;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_byte = 8'h00;
    logic       gate = 1'b1;
    logic       out_n;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    int    n_strobe = 0;
    int    n_exp_total = 0;
    bit    done = 1'b0;
    int    exp_cyc[$];
    string exp_tag[$];

    oneshot_strobe_timer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cw_wr        (cw_wr),
        .cw_gate_trig (cw_gate_trig),
        .cw_bcd       (cw_bcd),
        .cw_two_byte  (cw_two_byte),
        .cnt_wr       (cnt_wr),
        .cnt_byte     (cnt_byte),
        .gate         (gate),
        .out_n        (out_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Scoreboard monitor: each low out_n sample is matched against the queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_cyc.size() > 0 && cyc > exp_cyc[0]) begin
                chk(1'b0, {exp_tag[0], " missed strobe"}, cyc, exp_cyc[0]);
                void'(exp_cyc.pop_front());
                void'(exp_tag.pop_front());
            end
            if (!out_n && !cw_wr) begin
                n_strobe++;
                if (exp_cyc.size() == 0) begin
                    chk(1'b0, "R1/R9 unexpected strobe", cyc, -1);
                end else begin
                    chk(cyc == exp_cyc[0], exp_tag[0], cyc, exp_cyc[0]);
                    void'(exp_cyc.pop_front());
                    void'(exp_tag.pop_front());
                end
            end
        end
    end

    task automatic sync();
        @(negedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) sync();
    endtask

    task automatic expect_at(input int e, input string tag);
        exp_cyc.push_back(e);
        exp_tag.push_back(tag);
        n_exp_total++;
    endtask

    task automatic write_cw(input bit hw, input bit bcd, input bit two);
        sync();
        cw_wr = 1'b1; cw_gate_trig = hw; cw_bcd = bcd; cw_two_byte = two;
        sync();
        cw_wr = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b, output int k);
        sync();
        k = cyc + 1;
        cnt_wr = 1'b1; cnt_byte = b;
        sync();
        cnt_wr = 1'b0;
    endtask

    task automatic gate_rise(output int t);
        sync();
        t = cyc + 1;
        gate = 1'b1;
    endtask

    task automatic drain();
        while (exp_cyc.size() > 0) sync();
        idle(3);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", cyc, WD_CYCLES);
            report();
        end
    end

    initial begin
        int k, k2, t, t2;
        idle(4);
        // R1: idle level after reset
        chk(out_n == 1'b1, "R1 reset level", out_n, 1);
        rst_n = 1'b1;
        idle(2);

        // R2 R3: software single-byte count of 3
        write_cw(1'b0, 1'b0, 1'b0);
        write_byte(8'd3, k);
        expect_at(k + 4, "R2 sw load timing");
        drain();

        // R3: gate edges in software mode start nothing
        gate = 1'b0; idle(2); gate = 1'b1; idle(6);
        chk(n_strobe == n_exp_total, "R3 gate edge in sw mode", n_strobe, n_exp_total);

        // R4: software retrigger replaces the running sequence
        write_byte(8'd5, k);
        idle(2);
        write_byte(8'd4, k2);
        expect_at(k2 + 5, "R4 sw retrigger");
        drain();

        // R6: gate low pauses for three edges, delaying the strobe by three
        write_byte(8'd4, k);
        idle(1);
        gate = 1'b0;
        idle(3);
        gate = 1'b1;
        expect_at(k + 8, "R6 gate pause");
        drain();

        // R5: two-byte count 0x0014, low byte written mid-run has no effect
        write_cw(1'b0, 1'b0, 1'b1);
        write_byte(8'h14, k);
        idle(3);
        chk(n_strobe == n_exp_total, "R5 low byte alone", n_strobe, n_exp_total);
        write_byte(8'h00, k);
        expect_at(k + 21, "R5 two-byte count 20");
        idle(4);
        write_byte(8'h03, k2);
        drain();
        write_byte(8'h00, k);
        expect_at(k + 4, "R5 completed count 3");
        drain();

        // R9: no further strobe while the counter wraps
        idle(40);
        chk(n_strobe == n_exp_total, "R9 silent wrap", n_strobe, n_exp_total);

        // R7: gate mode, trigger ignored before any count
        gate = 1'b0;
        write_cw(1'b1, 1'b0, 1'b0);
        gate_rise(t);
        idle(8);
        gate = 1'b0;
        chk(n_strobe == n_exp_total, "R7 trigger without count", n_strobe, n_exp_total);

        // R7: write alone does not start, gate edge does
        write_byte(8'd3, k);
        idle(6);
        chk(n_strobe == n_exp_total, "R7 write alone", n_strobe, n_exp_total);
        gate_rise(t);
        expect_at(t + 4, "R7 gate trigger timing");
        sync(); gate = 1'b0;
        drain();

        // R8: retrigger restarts; a mid-run write keeps the timing
        write_byte(8'd6, k);
        gate_rise(t);
        sync(); gate = 1'b0;
        idle(2);
        gate_rise(t2);
        expect_at(t2 + 7, "R8 gate retrigger");
        sync(); gate = 1'b0;
        write_byte(8'd2, k);
        drain();
        gate_rise(t);
        expect_at(t + 3, "R8 new count on trigger");
        sync(); gate = 1'b0;
        drain();

        // R11: configuration write releases a strobe in the same cycle
        gate = 1'b1;
        write_cw(1'b0, 1'b0, 1'b0);
        write_byte(8'd3, k);
        expect_at(k + 4, "R11 strobe before release");
        while (cyc < k + 4) sync();
        chk(out_n == 1'b0, "R11 strobe present", out_n, 0);
        cw_wr = 1'b1;
        #1;
        chk(out_n == 1'b1, "R11 immediate release", out_n, 1);
        sync();
        cw_wr = 1'b0;

        // R11: configuration write cancels a running sequence
        write_byte(8'd6, k);
        idle(3);
        write_cw(1'b0, 1'b0, 1'b0);
        idle(15);
        chk(n_strobe == n_exp_total, "R11 cancel", n_strobe, n_exp_total);

        // R10: count 0 in BCD is 10000, in binary 65536
        write_cw(1'b0, 1'b1, 1'b0);
        write_byte(8'h00, k);
        expect_at(k + 10001, "R10 bcd zero count");
        drain();
        write_cw(1'b0, 1'b0, 1'b1);
        write_byte(8'h00, k);
        write_byte(8'h00, k);
        expect_at(k + 65537, "R10 binary zero count");
        drain();
        idle(20);
        chk(n_strobe == n_exp_total, "R9 strobe total", n_strobe, n_exp_total);

        done = 1'b1;
        report();
    end
endmodule